// File: doc/BRIEF.md
# External Area Chip-Select Generator

This block drives the active-low select strobes for the external memory areas of a microcontroller bus controller. A decoder upstream supplies the number of the area being accessed and a strobe that is high for every clock state of an external bus cycle. The block registers these inputs and pulls the matching select low, one clock later, for as many states as the strobe stays high. An external cycle may last one, two or three states. Accesses to on-chip memory or peripherals leave the strobe low, so they never assert a select.

Each select pin drives only when its port direction bit is set. The block holds the direction bits. A synchronous power-on reset loads them with a default that depends on the expansion mode, and the CPU can rewrite them later. The operating mode adds a further rule: in normal mode only the area 0 pin may ever drive. Any pin that is not allowed to drive has its output enable low, and the pad logic tri-states it.

Top module: `ext_sel_gen`

## Requirements
- R1: If `ext_cyc` is 1 with `area_id` = n at a rising edge, then bit n of the internal access vector is set for the next clock state, and `sel_n_o[n]` is 0 when that pin is enabled. A strobe held for one, two or three states gives the same number of consecutive low states.
- R2: If `ext_cyc` is 0 at a rising edge (an on-chip access or an idle cycle), then every bit of `sel_n_o` is 1 for the next state.
- R3: At most one bit of `sel_n_o` is 0 at any time.
- R4: `sel_oe_o[n]` equals direction bit n ANDed with the mode permission for pin n. When `sel_oe_o[n]` is 0, `sel_n_o[n]` reads 1 and the pin is treated as undriven.
- R5: When `mode_normal` is 1, `sel_oe_o[3:1]` is 0 and `sel_n_o[3:1]` stays 1, whatever the direction bits hold.
- R6: A reset with `rom_en` = 0 (ROM-disabled expansion) loads the direction bits with 4'b0001, so only the area 0 pin is an output.
- R7: A reset with `rom_en` = 1 (ROM-enabled expansion) loads the direction bits with 4'b0000, so all pins are inputs.
- R8: When `dir_we` is 1 at a rising edge, the direction bits take the value of `dir_wdata` from that edge on. Bit n controls pin n. If `rst` is high at the same edge, the reset value wins.
- R9: A pin that is enabled but not addressed has `sel_oe_o` = 1 and `sel_n_o` = 1, so it is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period is one bus state |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode_normal | input | 1 | 1 = normal mode (only area 0 select allowed), 0 = advanced mode |
| rom_en | input | 1 | 1 = ROM-enabled expansion, 0 = ROM-disabled expansion |
| ext_cyc | input | 1 | High in each state of an external bus cycle |
| area_id | input | 2 | Decoded external area number |
| dir_we | input | 1 | CPU write enable for the direction bits |
| dir_wdata | input | 4 | New direction bits, bit n for pin n |
| sel_n_o | output | 4 | Active-low select levels, one per area |
| sel_oe_o | output | 4 | Output enable per select pin; 0 means tri-stated |

## Verification
The bench builds the block with its default of four areas and a two-bit area code. With these values every area code names a real select, so random area numbers reach every pin. Random direction values and both settings of `mode_normal` cover every combination of enabled, masked and addressed pins. The bench applies a reset under each expansion setting to check both direction defaults, and it drives external strobes one, two and three states long.

// File: rtl/ext_sel_pkg.sv
package ext_sel_pkg;

  // Default direction bits loaded at power-on reset.
  // ROM-disabled expansion: only area 0 output. ROM-enabled: all inputs.
  function automatic logic [31:0] dir_default(input logic rom_enabled);
    return rom_enabled ? 32'h0 : 32'h1;
  endfunction

  // Pins allowed to drive in the current operating mode.
  function automatic logic [31:0] mode_allow(input logic normal);
    return normal ? 32'h1 : 32'hFFFF_FFFF;
  endfunction

endpackage

// File: rtl/sel_dir_reg.sv
module sel_dir_reg #(
  parameter int NSEL = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rom_en,
  input  logic            we,
  input  logic [NSEL-1:0] wdata,
  output logic [NSEL-1:0] dir_q
);
  import ext_sel_pkg::*;

  logic [31:0] rst_val;
  assign rst_val = dir_default(rom_en);

  always_ff @(posedge clk) begin
    if (rst)
      dir_q <= rst_val[NSEL-1:0];
    else if (we)
      dir_q <= wdata;
  end

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && !rst) |=> (dir_q == $past(wdata)))
    else $error("direction write not taken"); // R8

  AST_DIR_RST_ROMOFF: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(rom_en)) |-> (dir_q == NSEL'(1)))
    else $error("bad reset default, ROM disabled"); // R6

  AST_DIR_RST_ROMON: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(rom_en)) |-> (dir_q == '0))
    else $error("bad reset default, ROM enabled"); // R7

endmodule

// File: rtl/sel_area_dec.sv
module sel_area_dec #(
  parameter int NSEL = 4,
  parameter int AW   = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_cyc,
  input  logic [AW-1:0]   area,
  output logic [NSEL-1:0] act_q
);
  logic [NSEL-1:0] act_d;

  for (genvar i = 0; i < NSEL; i++) begin : g_dec
    assign act_d[i] = ext_cyc && (area == AW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= act_d;
  end

  AST_EXT_SELECTS: assert property (@(posedge clk) disable iff (rst)
    ext_cyc |=> (act_q == (NSEL'(1) << $past(area))))
    else $error("external access did not select its area"); // R1

  AST_ONCHIP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ext_cyc |=> (act_q == '0))
    else $error("select active without external cycle"); // R2

endmodule

// File: rtl/sel_pin_drv.sv
module sel_pin_drv #(
  parameter int NSEL = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_normal,
  input  logic [NSEL-1:0] dir_q,
  input  logic [NSEL-1:0] act_q,
  output logic [NSEL-1:0] sel_n,
  output logic [NSEL-1:0] sel_oe
);
  import ext_sel_pkg::*;

  logic [31:0] allow_w;
  assign allow_w = mode_allow(mode_normal);

  for (genvar i = 0; i < NSEL; i++) begin : g_pin
    assign sel_oe[i] = dir_q[i] & allow_w[i];
    assign sel_n[i]  = ~(act_q[i] & sel_oe[i]);
  end

  AST_ONE_LOW: assert property (@(posedge clk) disable iff (rst)
    $countones(~sel_n) <= 1)
    else $error("more than one select low"); // R3

  AST_UNDRIVEN_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((~sel_oe & ~sel_n) == '0))
    else $error("disabled pin reads low"); // R4

  if (NSEL > 1) begin : g_norm_chk
    AST_NORMAL_ONLY0: assert property (@(posedge clk) disable iff (rst)
      mode_normal |-> (sel_oe[NSEL-1:1] == '0))
      else $error("normal mode enabled an upper select"); // R5
  end

endmodule

// File: rtl/ext_sel_gen.sv
module ext_sel_gen #(
  parameter int NSEL = 4,
  parameter int AW   = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_normal,
  input  logic            rom_en,
  input  logic            ext_cyc,
  input  logic [AW-1:0]   area_id,
  input  logic            dir_we,
  input  logic [NSEL-1:0] dir_wdata,
  output logic [NSEL-1:0] sel_n_o,
  output logic [NSEL-1:0] sel_oe_o
);
  logic [NSEL-1:0] dir_q;
  logic [NSEL-1:0] act_q;

  sel_dir_reg #(.NSEL(NSEL)) u_dir (
    .clk   (clk),
    .rst   (rst),
    .rom_en(rom_en),
    .we    (dir_we),
    .wdata (dir_wdata),
    .dir_q (dir_q)
  );

  sel_area_dec #(.NSEL(NSEL), .AW(AW)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .ext_cyc(ext_cyc),
    .area   (area_id),
    .act_q  (act_q)
  );

  sel_pin_drv #(.NSEL(NSEL)) u_drv (
    .clk        (clk),
    .rst        (rst),
    .mode_normal(mode_normal),
    .dir_q      (dir_q),
    .act_q      (act_q),
    .sel_n      (sel_n_o),
    .sel_oe     (sel_oe_o)
  );

  AST_ENABLED_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !ext_cyc |=> ((sel_oe_o & ~sel_n_o) == '0))
    else $error("enabled unaddressed pin not high"); // R9

endmodule

// File: tb/ext_sel_gen_bench.sv
module ext_sel_gen_bench;
  localparam int NSEL = 4;
  localparam int AW   = 2;

  logic clk = 1'b0;
  logic rst, mode_normal, rom_en, ext_cyc, dir_we;
  logic [AW-1:0]   area_id;
  logic [NSEL-1:0] dir_wdata;
  logic [NSEL-1:0] sel_n_o, sel_oe_o;

  int errors = 0;
  int checks = 0;
  logic [NSEL-1:0] m_dir, m_act;
  bit done = 0;

  always #5 clk = ~clk;

  ext_sel_gen #(.NSEL(NSEL), .AW(AW)) u_ext_sel_gen (
    .clk(clk), .rst(rst), .mode_normal(mode_normal), .rom_en(rom_en),
    .ext_cyc(ext_cyc), .area_id(area_id), .dir_we(dir_we),
    .dir_wdata(dir_wdata), .sel_n_o(sel_n_o), .sel_oe_o(sel_oe_o)
  );

  function automatic logic [NSEL-1:0] exp_oe(input logic [NSEL-1:0] d, input logic nm);
    return nm ? (d & NSEL'(1)) : d;
  endfunction

  function automatic logic [NSEL-1:0] exp_seln(input logic [NSEL-1:0] a,
                                              input logic [NSEL-1:0] d, input logic nm);
    return ~(a & exp_oe(d, nm));
  endfunction

  task automatic check(input string req);
    logic [NSEL-1:0] eo, es;
    eo = exp_oe(m_dir, mode_normal);
    es = exp_seln(m_act, m_dir, mode_normal);
    checks++;
    if (sel_oe_o !== eo || sel_n_o !== es) begin
      errors++;
      $display("FAIL %s: oe=%b sel_n=%b expected oe=%b sel_n=%b",
               req, sel_oe_o, sel_n_o, eo, es);
    end
  endtask

  // One clock state: inputs applied now, model updated at the edge, checked at the negedge.
  task automatic step(input logic r, input logic ext, input logic [AW-1:0] ar,
                      input logic we, input logic [NSEL-1:0] wd, input string req);
    rst = r; ext_cyc = ext; area_id = ar; dir_we = we; dir_wdata = wd;
    @(posedge clk);
    if (r) begin
      m_dir = rom_en ? '0 : NSEL'(1);
      m_act = '0;
    end else begin
      if (we) m_dir = wd;
      m_act = ext ? (NSEL'(1) << ar) : '0;
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_dir = '0; m_act = '0;
    rst = 1; mode_normal = 0; rom_en = 0; ext_cyc = 0; area_id = '0;
    dir_we = 0; dir_wdata = '0;
    @(negedge clk);

    // R6: reset, ROM-disabled advanced mode -> only pin 0 enabled, all high
    step(1, 0, 0, 0, '0, "R6");
    step(0, 0, 0, 0, '0, "R6");
    // R1: three-state access to area 0
    for (int k = 0; k < 3; k++) step(0, 1, 0, 0, '0, "R1");
    step(0, 0, 0, 0, '0, "R2");
    // R4: access to area 2 while pin 2 is an input -> stays high, undriven
    step(0, 1, 2, 0, '0, "R4");
    // R8: write direction, reset wins over a simultaneous write
    step(0, 0, 0, 1, 4'b1110, "R8");
    step(1, 0, 0, 1, 4'b1111, "R8");
    // R7: reset in ROM-enabled mode -> all inputs
    rom_en = 1;
    step(1, 1, 3, 0, '0, "R7");
    step(0, 1, 3, 0, '0, "R7");
    // R9: enable all, access area 1 for two states, others driven high
    step(0, 0, 0, 1, 4'b1111, "R9");
    step(0, 1, 1, 0, '0, "R9");
    step(0, 1, 1, 0, '0, "R1");
    step(0, 0, 1, 0, '0, "R2");
    // R5: normal mode masks pins 1..3 even with all direction bits set
    mode_normal = 1;
    step(0, 1, 3, 0, '0, "R5");
    step(0, 1, 0, 0, '0, "R5");
    rom_en = 0;
    step(1, 0, 0, 0, '0, "R6");
    step(0, 1, 0, 0, '0, "R1");

    // Random mix across modes
    for (int i = 0; i < 3000; i++) begin
      logic r, e, w;
      if (($urandom % 200) == 0) begin
        mode_normal = $urandom % 2;
        rom_en = $urandom % 2;
      end
      r = (($urandom % 100) == 0);
      e = ($urandom % 3) != 0;
      w = (($urandom % 10) == 0);
      step(r, e, AW'($urandom), w, NSEL'($urandom), "R3");
      if ($countones(~sel_n_o) > 1) begin
        errors++;
        $display("FAIL R3: sel_n=%b expected at most one low", sel_n_o);
      end
      checks++;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule